// File: doc/BRIEF.md
# Oversampled Serial Receiver Data Recovery

This block recovers 8-bit asynchronous frames from a single serial line. A sample enable, `sample_tick`, pulses sixteen times per bit period. Only clocks on which it is high take a sample of `serial_in`. The receiver waits for a qualified falling edge and aligns a phase counter that runs from 1 to 16 to that edge. It checks the start bit with three early samples. It then takes each data bit and the stop bit as the majority of the three samples in the middle of the bit.

A finished frame is placed on `rx_byte` and marked by a one-clock `byte_ready` pulse. Sticky status outputs report three conditions: votes that disagreed, a stop position that was not high, and a frame that finished while the previous byte was still unacknowledged. A one-clock `flag_clear` pulse acknowledges all of them. The bit-rate generator that produces `sample_tick` lives outside this block.

The controller has four states:
- `ST_HUNT`: waits for a start edge.
- `ST_START`: verifies the start bit.
- `ST_DATA`: collects the data bits.
- `ST_STOP`: evaluates the stop bit.

The transitions between them are:
- edge_seen: `ST_HUNT` to `ST_START`.
- start_reject: `ST_START` to `ST_HUNT`.
- start_ok: `ST_START` to `ST_DATA`, at phase 16 of the start bit.
- last_bit_done: `ST_DATA` to `ST_STOP`, at phase 16 of the eighth data bit.
- frame_done: `ST_STOP` to `ST_HUNT`, at the stop bit's phase 10 sample.

Top module: `rx_oversample_recovery`

## Requirements
- R1: Right after reset, `rx_byte` is 0x00 and `byte_ready`, `data_full`, `noise_flag`, `frame_err` and `overrun` are all 0.
- R2: A frame begins only on a ticked low sample whose three preceding ticked samples were all high. The sample history starts as all zeros at reset, so a low sample preceded by fewer than three highs starts nothing. The qualifying low sample is phase 1 of the start bit.
- R3: The start bit is checked at phases 3, 5 and 7. If two or more of these samples are high, the frame is abandoned: no byte is delivered, `noise_flag` is unchanged and the hunt for an edge resumes.
- R4: If exactly one of the phase 3, 5 and 7 start samples is high, `noise_flag` is set and the frame continues.
- R5: A frame is one low start bit, eight data bits with the least significant bit first, and one stop bit, each 16 ticked samples long. Each data bit is the majority of its phase 8, 9 and 10 samples. The byte appears on `rx_byte`, with `byte_ready` high for exactly one clock. That clock follows the edge that takes the stop bit's phase 10 sample, and `data_full` is set at the same time.
- R6: When the three voting samples of a data bit or the stop bit are not all equal, `noise_flag` is set and the bit still takes the majority value. The phase counter is not realigned: a phase 10 sample is followed by phase 11. Data-bit samples outside phases 8 to 10 affect neither the byte nor the flags.
- R7: When the stop bit's majority is 0, `frame_err` is set, and it rises in the same clock that `byte_ready` is high. An all-low frame, with a low stop bit, delivers 0x00 with `frame_err` set.
- R8: `noise_flag`, `frame_err`, `overrun` and `data_full` stay set until `flag_clear` is high for one clock, which clears all four.
- R9: If a frame completes while `data_full` is still set, `overrun` is set and `rx_byte` takes the new byte.
- R10: Clocks with `sample_tick` low change neither the controller nor the phase counter, whatever `serial_in` does.
- R11: The start bit's phase 8, 9 and 10 samples are not voted. High values there set no flag and do not change the received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Sample enable at 16 times the bit rate |
| serial_in | input | 1 | Serial line, already synchronous to `clk` |
| flag_clear | input | 1 | One-clock pulse that clears the sticky flags |
| rx_byte | output | 8 | Last received byte |
| byte_ready | output | 1 | One-clock pulse when a frame completes |
| data_full | output | 1 | A byte has arrived since the last clear |
| noise_flag | output | 1 | Sticky: a start check or a vote disagreed |
| frame_err | output | 1 | Sticky: the stop position was not high |
| overrun | output | 1 | Sticky: a frame finished while `data_full` was set |

## Verification
Some properties are checked on every clock by the assertions:
- `frame_err` and `overrun` rise only together with `byte_ready`.
- `byte_ready` lasts a single clock and always comes with `data_full`.
- Every entry into `ST_START` follows a full high history and a ticked low sample.
- The phase stays within 1 to 16 and keeps counting past the data votes.
- Untick clocks freeze the controller.

Whether the right bits are recovered can only be shown by the bench's frames. These cover all 256 byte values, injected glitches at voting and non-voting phases, rejected and noisy start bits, low stop bits, breaks, and back-to-back frames without a clear.

// File: rtl/rxrec_pkg.sv
package rxrec_pkg;

    // Receiver controller states
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/rxrec_edge_qual.sv
module rxrec_edge_qual #(
    parameter int HIST_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sample,
    output logic hist_full,
    output logic edge_hit
);

    logic [HIST_LEN-1:0] hist_q;

    // History of the most recent ticked samples, cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (tick) begin
            hist_q <= {hist_q[HIST_LEN-2:0], sample};
        end
    end

    assign hist_full = &hist_q;
    assign edge_hit  = tick & ~sample & hist_full;

    // R2: the history can only become full after a ticked high sample
    assert_hist_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hist_full) |-> $past(tick && sample))
        else $error("history filled without a ticked high sample");

endmodule

// File: rtl/rxrec_phase.sv
module rxrec_phase #(
    parameter int OSR = 16,
    parameter int PW  = $clog2(OSR + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic          run,
    output logic [PW-1:0] phase
);

    localparam logic [PW-1:0] PH_FIRST  = PW'(1);
    localparam logic [PW-1:0] PH_SECOND = PW'(2);
    localparam logic [PW-1:0] PH_LAST   = PW'(OSR);

    // phase holds the sample position of the next ticked sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_FIRST;
        end else if (tick) begin
            if (load) begin
                phase <= PH_SECOND;
            end else if (run) begin
                phase <= (phase == PH_LAST) ? PH_FIRST : phase + PW'(1);
            end
        end
    end

    // R6: the phase never leaves the range 1..OSR
    assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase >= PH_FIRST) && (phase <= PH_LAST))
        else $error("phase out of range");

endmodule

// File: rtl/rxrec_vote.sv
module rxrec_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take_first,
    input  logic take_mid,
    input  logic take_last,
    input  logic sample,
    output logic decide,
    output logic majority,
    output logic split,
    output logic single_high
);

    logic [1:0] part_q;
    logic [1:0] total;

    // Running count of high samples among the first two voting positions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q <= '0;
        end else if (tick) begin
            if (take_first) begin
                part_q <= {1'b0, sample};
            end else if (take_mid) begin
                part_q <= part_q + {1'b0, sample};
            end
        end
    end

    assign total       = part_q + {1'b0, sample};
    assign decide      = tick & take_last;
    assign majority    = total[1];
    assign split       = (total != 2'd0) && (total != 2'd3);
    assign single_high = (total == 2'd1);

endmodule

// File: rtl/rx_oversample_recovery.sv
module rx_oversample_recovery
    import rxrec_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int DATA_BITS = 8,
    parameter int HIST_LEN  = 3,
    parameter int CHK_A     = 3,
    parameter int CHK_B     = 5,
    parameter int CHK_C     = 7,
    parameter int VOTE_A    = OSR / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_tick,
    input  logic                 serial_in,
    input  logic                 flag_clear,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 byte_ready,
    output logic                 data_full,
    output logic                 noise_flag,
    output logic                 frame_err,
    output logic                 overrun
);

    localparam int PW = $clog2(OSR + 1);
    localparam int BW = $clog2(DATA_BITS);

    localparam logic [PW-1:0] PH_CA    = PW'(CHK_A);
    localparam logic [PW-1:0] PH_CB    = PW'(CHK_B);
    localparam logic [PW-1:0] PH_CC    = PW'(CHK_C);
    localparam logic [PW-1:0] PH_VA    = PW'(VOTE_A);
    localparam logic [PW-1:0] PH_VB    = PW'(VOTE_A + 1);
    localparam logic [PW-1:0] PH_VC    = PW'(VOTE_A + 2);
    localparam logic [PW-1:0] PH_AFTER = PW'(VOTE_A + 3);
    localparam logic [PW-1:0] PH_LAST  = PW'(OSR);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

    rx_state_e state_q, state_d;

    logic [PW-1:0]        phase;
    logic                 hist_full, edge_hit;
    logic                 hunting, in_start, in_data, in_stop, in_bits;
    logic                 start_go, bit_end;
    logic                 take_first, take_mid, take_last;
    logic                 vote_decide, vote_maj, vote_split, vote_single;
    logic                 start_noise, data_take, stop_done;
    logic                 noise_set, fe_set, ovr_set;
    logic [BW-1:0]        bit_q;
    logic [DATA_BITS-1:0] shreg_q;

    assign hunting  = (state_q == ST_HUNT);
    assign in_start = (state_q == ST_START);
    assign in_data  = (state_q == ST_DATA);
    assign in_stop  = (state_q == ST_STOP);
    assign in_bits  = in_data | in_stop;

    assign start_go = edge_hit & hunting;
    assign bit_end  = sample_tick & (phase == PH_LAST);

    // Start bit is checked at early phases; data and stop bits are voted
    // mid-bit; the start bit's mid-bit samples are never voted (R11)
    assign take_first = (in_start & (phase == PH_CA)) | (in_bits & (phase == PH_VA));
    assign take_mid   = (in_start & (phase == PH_CB)) | (in_bits & (phase == PH_VB));
    assign take_last  = (in_start & (phase == PH_CC)) | (in_bits & (phase == PH_VC));

    rxrec_edge_qual #(
        .HIST_LEN (HIST_LEN)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sample_tick),
        .sample    (serial_in),
        .hist_full (hist_full),
        .edge_hit  (edge_hit)
    );

    rxrec_phase #(
        .OSR (OSR),
        .PW  (PW)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sample_tick),
        .load  (start_go),
        .run   (!hunting),
        .phase (phase)
    );

    rxrec_vote u_vote (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (sample_tick),
        .take_first  (take_first),
        .take_mid    (take_mid),
        .take_last   (take_last),
        .sample      (serial_in),
        .decide      (vote_decide),
        .majority    (vote_maj),
        .split       (vote_split),
        .single_high (vote_single)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (start_go) state_d = ST_START;                       // edge_seen
            end
            ST_START: begin
                if (vote_decide && vote_maj) state_d = ST_HUNT;         // start_reject
                else if (bit_end)            state_d = ST_DATA;         // start_ok
            end
            ST_DATA: begin
                if (bit_end && (bit_q == LAST_BIT)) state_d = ST_STOP;  // last_bit_done
            end
            ST_STOP: begin
                if (vote_decide) state_d = ST_HUNT;                     // frame_done
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    assign start_noise = vote_decide & in_start & vote_single;
    assign data_take   = vote_decide & in_data;
    assign stop_done   = vote_decide & in_stop;
    assign noise_set   = start_noise | ((data_take | stop_done) & vote_split);
    assign fe_set      = stop_done & ~vote_maj;
    assign ovr_set     = stop_done & data_full;

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q      <= '0;
            shreg_q    <= '0;
            rx_byte    <= '0;
            byte_ready <= 1'b0;
            data_full  <= 1'b0;
            noise_flag <= 1'b0;
            frame_err  <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            if (start_go) begin
                bit_q <= '0;
            end else if (in_data && bit_end) begin
                bit_q <= bit_q + BW'(1);
            end
            if (data_take) begin
                shreg_q <= {vote_maj, shreg_q[DATA_BITS-1:1]};
            end
            if (stop_done) begin
                rx_byte <= shreg_q;
            end
            byte_ready <= stop_done;
            data_full  <= (data_full  & ~flag_clear) | stop_done;
            noise_flag <= (noise_flag & ~flag_clear) | noise_set;
            frame_err  <= (frame_err  & ~flag_clear) | fe_set;
            overrun    <= (overrun    & ~flag_clear) | ovr_set;
        end
    end

    // R7: a framing error appears together with the ready pulse
    assert_fe_with_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> byte_ready)
        else $error("frame_err rose without byte_ready");

    // R9: overrun only on a completion while the previous byte is pending
    assert_ovr_with_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> (byte_ready && $past(data_full)))
        else $error("overrun rose without a pending completion");

    // R5: the ready strobe lasts a single clock
    assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |=> !byte_ready)
        else $error("byte_ready longer than one clock");

    // R8: a delivered byte is always marked pending
    assert_ready_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> data_full)
        else $error("byte_ready without data_full");

    // R2: entering start verification needs a full high history and a ticked low
    assert_start_history_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_start && ($past(state_q) == ST_HUNT)) |->
            $past(hist_full && !serial_in && sample_tick))
        else $error("start entered without qualified edge");

    // R6: data votes never realign the phase counter
    assert_no_resync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && sample_tick && (phase == PH_VC)) |=> (phase == PH_AFTER))
        else $error("phase realigned after a data vote");

    // R10: clocks without a tick hold the controller and phase
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> ($stable(state_q) && $stable(phase) && $stable(rx_byte)))
        else $error("state moved without a tick");

endmodule

// File: tb/tb_rx_oversample_recovery.sv
`timescale 1ns/1ps
module tb_rx_oversample_recovery;

    localparam int FS = 160;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       serial_in = 1'b1;
    logic       flag_clear = 1'b0;
    logic [7:0] rx_byte;
    logic       byte_ready, data_full, noise_flag, frame_err, overrun;

    int checks = 0;
    int fails = 0;
    int high_run = 0;
    int ev_cnt = 0;
    logic [7:0] cap_byte = '0;
    logic cap_fe = 1'b0;
    logic cap_fe_before = 1'b0;
    logic last_fe = 1'b0;
    bit noise_m = 0, fe_m = 0, ovr_m = 0, full_m = 0;

    always #2 clk = ~clk;

    rx_oversample_recovery dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .serial_in   (serial_in),
        .flag_clear  (flag_clear),
        .rx_byte     (rx_byte),
        .byte_ready  (byte_ready),
        .data_full   (data_full),
        .noise_flag  (noise_flag),
        .frame_err   (frame_err),
        .overrun     (overrun)
    );

    // Capture ready events away from the active edge
    always @(negedge clk) begin
        if (byte_ready) begin
            ev_cnt = ev_cnt + 1;
            cap_byte = rx_byte;
            cap_fe = frame_err;
            cap_fe_before = last_fe;
        end
        last_fe = frame_err;
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sample_tick = 1'b0;
        serial_in = 1'b1;
        flag_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        high_run = 0;
        noise_m = 0; fe_m = 0; ovr_m = 0; full_m = 0;
    endtask

    task automatic drive_sample(input logic v);
        @(negedge clk);
        serial_in = v;
        sample_tick = 1'b1;
        high_run = v ? high_run + 1 : 0;
        @(negedge clk);
        sample_tick = 1'b0;
        serial_in = ~v;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        flag_clear = 1'b1;
        @(negedge clk);
        flag_clear = 1'b0;
        noise_m = 0; fe_m = 0; ovr_m = 0; full_m = 0;
    endtask

    function automatic logic [FS-1:0] fl(input int bi, input int rt);
        logic [FS-1:0] m;
        m = '0;
        m[bi*16 + rt - 1] = 1'b1;
        return m;
    endfunction

    task automatic check_flags();
        check_eq("R6", "noise_flag", int'(noise_flag), int'(noise_m));
        check_eq("R7", "frame_err", int'(frame_err), int'(fe_m));
        check_eq("R9", "overrun", int'(overrun), int'(ovr_m));
        check_eq("R8", "data_full", int'(data_full), int'(full_m));
    endtask

    task automatic send_frame(input string tag, input int n_idle, input logic [7:0] d,
                              input logic stop_v, input logic [FS-1:0] flip, input int n_tail);
        logic [FS-1:0] s;
        logic [7:0] byte_e;
        int h, ev0, ones;
        bit qual, acc, split_any, fe_e;
        byte_e = '0;
        fe_e = 0;
        for (int k = 0; k < FS; k++) begin
            int bi = k / 16;
            logic b;
            b = (bi == 0) ? 1'b0 : (bi == 9) ? stop_v : d[bi-1];
            s[k] = b ^ flip[k];
        end
        for (int i = 0; i < n_idle; i++) drive_sample(1'b1);
        qual = (high_run >= 3) && (s[0] == 1'b0);
        h = int'(s[2]) + int'(s[4]) + int'(s[6]);
        acc = qual && (h < 2);
        split_any = (h == 1);
        for (int bi = 1; bi <= 9; bi++) begin
            ones = int'(s[bi*16+7]) + int'(s[bi*16+8]) + int'(s[bi*16+9]);
            if (ones == 1 || ones == 2) split_any = 1;
            if (bi <= 8) byte_e[bi-1] = (ones >= 2);
            else         fe_e = (ones < 2);
        end
        ev0 = ev_cnt;
        for (int k = 0; k < FS; k++) drive_sample(s[k]);
        for (int i = 0; i < n_tail; i++) drive_sample(1'b1);
        check_eq(tag, "ready events", ev_cnt - ev0, acc ? 1 : 0);
        if (acc) begin
            check_eq(tag, "rx_byte", int'(cap_byte), int'(byte_e));
            check_eq("R7", "frame_err at ready", int'(cap_fe), int'(fe_e | fe_m));
            if (fe_e && !fe_m)
                check_eq("R7", "frame_err before ready", int'(cap_fe_before), 0);
            noise_m = noise_m | split_any;
            fe_m = fe_m | fe_e;
            if (full_m) ovr_m = 1;
            full_m = 1;
        end
        check_flags();
    endtask

    initial begin : watchdog
        #(4 * 180000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1: reset state
        @(negedge clk);
        check_eq("R1", "rx_byte", int'(rx_byte), 0);
        check_eq("R1", "byte_ready", int'(byte_ready), 0);
        check_eq("R1", "data_full", int'(data_full), 0);
        check_eq("R1", "noise_flag", int'(noise_flag), 0);
        check_eq("R1", "frame_err", int'(frame_err), 0);
        check_eq("R1", "overrun", int'(overrun), 0);

        // R2: no history after reset, then too short a history, then exactly three highs
        send_frame("R2", 0, 8'hFF, 1'b1, '0, 4);
        do_reset();
        send_frame("R2", 2, 8'hFF, 1'b1, '0, 4);
        do_reset();
        send_frame("R2", 3, 8'h5A, 1'b1, '0, 4);
        pulse_clear();

        // R10: line activity with the tick held low starts nothing
        begin
            int ev0;
            ev0 = ev_cnt;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                serial_in = (i % 5 == 4) ? 1'b0 : 1'b1;
            end
            repeat (400) @(negedge clk);
            check_eq("R10", "ready events without tick", ev_cnt - ev0, 0);
            check_eq("R10", "rx_byte held", int'(rx_byte), 8'h5A);
        end
        send_frame("R10", 0, 8'hC3, 1'b1, '0, 4);
        pulse_clear();

        // R5: every byte value, clean frames
        for (int v = 0; v < 256; v++) begin
            send_frame("R5", 0, 8'(v), 1'b1, '0, 4);
            pulse_clear();
        end

        // R3: start rejected by two or three high checks
        send_frame("R3", 0, 8'hFF, 1'b1, fl(0,3) | fl(0,5), 4);
        send_frame("R3", 0, 8'hFF, 1'b1, fl(0,3) | fl(0,5) | fl(0,7), 4);
        send_frame("R3", 0, 8'hFF, 1'b1, fl(0,5) | fl(0,7), 4);

        // R4: one high start check sets noise
        send_frame("R4", 0, 8'hA5, 1'b1, fl(0,5), 4);
        pulse_clear();
        send_frame("R4", 0, 8'h3C, 1'b1, fl(0,7), 4);
        pulse_clear();

        // R11: mid-bit samples of the start bit are not voted
        send_frame("R11", 0, 8'h81, 1'b1, fl(0,8) | fl(0,9) | fl(0,10), 4);
        send_frame("R11", 0, 8'h42, 1'b1, fl(0,12) | fl(0,16), 4);
        pulse_clear();

        // R6: disagreeing votes, majority kept, phase not realigned
        send_frame("R6", 0, 8'h00, 1'b1, fl(4,9), 4);
        pulse_clear();
        send_frame("R6", 0, 8'h00, 1'b1, fl(6,8) | fl(6,10), 4);
        pulse_clear();
        send_frame("R6", 0, 8'h0F, 1'b1, fl(2,4) | fl(5,14) | fl(7,1) | fl(8,16), 4);
        pulse_clear();
        send_frame("R6", 0, 8'h99, 1'b1, fl(9,9), 4);
        pulse_clear();

        // R7: low stop bit, break, and a stop voted low by two samples
        send_frame("R7", 0, 8'h3C, 1'b0, '0, 4);
        pulse_clear();
        send_frame("R7", 0, 8'h00, 1'b0, '0, 4);
        pulse_clear();
        send_frame("R7", 0, 8'h77, 1'b1, fl(9,8) | fl(9,10), 4);
        pulse_clear();

        // R9: two frames without a clear
        send_frame("R9", 0, 8'h11, 1'b1, '0, 4);
        send_frame("R9", 0, 8'h22, 1'b1, '0, 4);
        check_eq("R9", "rx_byte replaced", int'(rx_byte), 8'h22);
        check_eq("R9", "overrun set", int'(overrun), 1);

        // R8: one clear pulse drops every sticky flag
        pulse_clear();
        @(negedge clk);
        check_flags();
        check_eq("R8", "overrun cleared", int'(overrun), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule